// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block takes received Ethernet frames, one byte per beat, from an AXI4-Stream input. It computes the frame check sequence on the fly and appends it after the payload. It then scatters the payload and its four check bytes over a ring of receive buffer descriptors held in system memory, using a single word-wide memory master port. Each descriptor is two words. The word at the descriptor address carries a 16-bit status field in bits 31:16 and a 16-bit byte count in bits 15:0. The word at descriptor address + 4 holds the buffer address.

For each descriptor it fills, the engine writes back the byte count and the updated status. It then signals one of two events. A one-cycle rx-buffer pulse marks a descriptor that holds part of a frame. A one-cycle rx-frame pulse marks the descriptor that closes a frame. Over-long frames are cut at a fixed ceiling. Frames longer than a software limit are marked, but only in the closing descriptor.

Between frames the engine decides whether reception stays active by reading the status of the next descriptor. Software re-arms a stalled ring with a single activate pulse.

Top module: `rxq_ring_engine`

## Requirements
- R1: After the last payload byte, four check bytes are stored. They are the inverted value of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones), stored least significant byte first. The four bytes count in the descriptor byte counts and may spill into a following buffer.
- R2: A frame is stored with at most FRAME_LIMIT (default 2032) bytes, check bytes included. Extra payload is accepted and dropped. The check value still covers the whole payload. The closing descriptor then gets status bits 0 (truncated) and 5 (long). A frame of exactly FRAME_LIMIT stored bytes is not truncated.
- R3: Status bit 5 is set in the closing descriptor when the stored byte count of the frame exceeds `max_frame_len`. It is not set when the count equals `max_frame_len`.
- R4: A buffer takes at most `buf_units`×16 bytes, or 16 bytes when `buf_units` is 0.
- R5: Only a descriptor with status bit 15 (empty) set is filled. When the next descriptor of a frame is not empty, the rest of the frame is consumed and discarded. No further memory write is made for that frame.
- R6: A filled descriptor has status bit 15 cleared, its other status bits kept and its byte count written. The closing descriptor also gets status bit 11 (last) plus the error bits and raises `evt_rxf`. Every other descriptor raises `evt_rxb`.
- R7: After a descriptor, the next one is at `ring_base` when its status bit 13 (wrap) is set, and otherwise at the current address + 8. While `ctl_enable` is low and no frame is in progress, the current descriptor is reloaded from `ring_base`.
- R8: After each frame, `rx_active` is set to status bit 15 of the next descriptor. An `rx_activate` pulse while enabled and inactive reads that descriptor again and sets `rx_active` from it.
- R9: `rx_active` falls on the clock after `ctl_enable` goes low. While `rx_active` is low and no frame is in progress, `s_tready` stays low.
- R10: A memory request keeps `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` stable until the cycle `mem_ack` is high. Read data is taken in that cycle. The buffer byte at offset k goes in bits 8·(k mod 4)+7:8·(k mod 4) of its word, and buffer addresses are rounded down to a word.
- R11: A word write to a buffer enables only the byte lanes that hold frame bytes. Descriptor writes enable all four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller enable level |
| rx_activate | input | 1 | Pulse: re-check the next descriptor |
| ring_base | input | AW | Address of the first ring descriptor |
| buf_units | input | 7 | Maximum buffer size in 16-byte units |
| max_frame_len | input | 16 | Frame length above which status bit 5 is set |
| s_tdata | input | 8 | Stream byte |
| s_tvalid | input | 1 | Stream valid |
| s_tlast | input | 1 | Last payload byte of the frame |
| s_tready | output | 1 | Stream ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| rx_active | output | 1 | Receive is active |
| evt_rxb | output | 1 | Pulse: a non-closing buffer was filled |
| evt_rxf | output | 1 | Pulse: a frame was closed |

## Verification
The bench builds the engine with its default parameters: AW = 32 and FRAME_LIMIT = 2032. This keeps the true truncation ceiling within reach. A 2100-byte frame and a frame of exactly 2028 payload bytes then cover both sides of the cut, and a buffer size of 127 units lets a ceiling-sized frame fit in one buffer. At run time the bench changes the buffer size and the length limit. This covers check bytes spilling over a buffer edge, the length limit at and above equality, wrap-around in a six-entry ring, a hole in the ring, and disable with reload of the ring start.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Status bit positions inside the 16-bit descriptor status field
    localparam int FLG_EMPTY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;
    localparam int FLG_LONG  = 5;
    localparam int FLG_TRUNC = 0;

    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 8;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FLAGS,
        ST_RD_PTR,
        ST_FILL,
        ST_WR_DATA,
        ST_WR_DESC,
        ST_DROP,
        ST_CHK
    } rxq_state_e;

    typedef struct packed {
        logic [15:0] status;
        logic [15:0] count;
    } desc_head_t;

    // One byte of reflected CRC-32
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxq_crc_unit.sv
module rxq_crc_unit
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc_step(crc_q, din);
        end
    end

    assign fcs = ~crc_q;
endmodule

// File: rtl/rxq_word_packer.sv
module rxq_word_packer #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               put,
    input  logic [LW-1:0]      lane,
    input  logic [7:0]         din,
    output logic [8*LANES-1:0] word,
    output logic [LANES-1:0]   be
);
    logic [7:0] byte_q [LANES];
    logic       used_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                byte_q[g] <= '0;
                used_q[g] <= 1'b0;
            end else if (put && (lane == LW'(g))) begin
                byte_q[g] <= din;
                used_q[g] <= 1'b1;
            end
        end
        assign word[8*g +: 8] = byte_q[g];
        assign be[g]          = used_q[g];
    end

    // a lane is written only once between flushes
    AST_LANE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (put && !clr) |-> (be[lane] == 1'b0)); // R11
endmodule

// File: rtl/rxq_ring_engine.sv
module rxq_ring_engine
    import rxq_pkg::*;
#(
    parameter int AW          = 32,
    parameter int FRAME_LIMIT = 2032,
    localparam int CNT_W      = $clog2(FRAME_LIMIT + 1),
    localparam int PAY_MAX    = FRAME_LIMIT - 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_enable,
    input  logic          rx_activate,
    input  logic [AW-1:0] ring_base,
    input  logic [6:0]    buf_units,
    input  logic [15:0]   max_frame_len,
    input  logic [7:0]    s_tdata,
    input  logic          s_tvalid,
    input  logic          s_tlast,
    output logic          s_tready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          rx_active,
    output logic          evt_rxb,
    output logic          evt_rxf
);
    rxq_state_e    st;
    logic [AW-1:0] cur_desc;
    logic [AW-1:0] wr_ptr;
    logic [15:0]   hdr_status;
    logic [CNT_W-1:0] buf_cnt, frame_cnt, pay_cnt, buf_cap;
    logic          crc_phase;
    logic [1:0]    crc_idx;
    logic          trunc;
    logic          frame_done;

    logic [31:0]   fcs;
    logic [31:0]   pk_word;
    logic [3:0]    pk_be;
    logic          byte_ok, skip, store, last_byte, flush, pk_clr;
    logic [7:0]    cur_byte;
    logic          long_err;
    desc_head_t    head_out;

    // byte source: payload first, then the four check bytes
    assign buf_cap   = (buf_units == 7'd0) ? CNT_W'(16) : CNT_W'({buf_units, 4'b0000});
    assign cur_byte  = crc_phase ? fcs[8*crc_idx +: 8] : s_tdata;
    assign byte_ok   = (st == ST_FILL) && (crc_phase || s_tvalid);
    assign skip      = !crc_phase && (pay_cnt == CNT_W'(PAY_MAX));
    assign store     = byte_ok && !skip;
    assign last_byte = crc_phase && (crc_idx == 2'd3);
    assign flush     = (buf_cnt[1:0] == 2'd3) || (buf_cnt + CNT_W'(1) == buf_cap) || last_byte;
    assign s_tready  = ((st == ST_FILL) || (st == ST_DROP)) && !crc_phase;
    assign pk_clr    = (st == ST_WR_DATA) && mem_ack;

    assign long_err = trunc || (16'(frame_cnt) > max_frame_len);

    always_comb begin
        head_out.status = hdr_status & ~(16'd1 << FLG_EMPTY);
        if (frame_done) begin
            head_out.status[FLG_LAST] = 1'b1;
            if (trunc)    head_out.status[FLG_TRUNC] = 1'b1;
            if (long_err) head_out.status[FLG_LONG]  = 1'b1;
        end
        head_out.count = 16'(buf_cnt);
    end

    rxq_crc_unit u_crc (
        .clk (clk),
        .rst (rst),
        .clr (st == ST_IDLE),
        .en  (s_tvalid && s_tready),
        .din (s_tdata),
        .fcs (fcs)
    );

    rxq_word_packer #(.LANES(WORD_BYTES)) u_pack (
        .clk  (clk),
        .rst  (rst),
        .clr  (pk_clr),
        .put  (store),
        .lane (buf_cnt[1:0]),
        .din  (cur_byte),
        .word (pk_word),
        .be   (pk_be)
    );

    // memory request mux
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc;
        mem_be    = 4'hF;
        mem_wdata = '0;
        unique case (st)
            ST_RD_FLAGS, ST_CHK: mem_req = 1'b1;
            ST_RD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc + AW'(WORD_BYTES);
            end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_ptr;
                mem_be    = pk_be;
                mem_wdata = pk_word;
            end
            ST_WR_DESC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = head_out;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur_desc   <= '0;
            wr_ptr     <= '0;
            hdr_status <= '0;
            buf_cnt    <= '0;
            frame_cnt  <= '0;
            pay_cnt    <= '0;
            crc_phase  <= 1'b0;
            crc_idx    <= '0;
            trunc      <= 1'b0;
            frame_done <= 1'b0;
            rx_active  <= 1'b0;
            evt_rxb    <= 1'b0;
            evt_rxf    <= 1'b0;
        end else begin
            evt_rxb <= 1'b0;
            evt_rxf <= 1'b0;
            if (!ctl_enable) rx_active <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (!ctl_enable) begin
                        cur_desc <= ring_base;
                    end else if (rx_active && s_tvalid) begin
                        st         <= ST_RD_FLAGS;
                        buf_cnt    <= '0;
                        frame_cnt  <= '0;
                        pay_cnt    <= '0;
                        crc_phase  <= 1'b0;
                        crc_idx    <= '0;
                        trunc      <= 1'b0;
                        frame_done <= 1'b0;
                    end else if (rx_activate && !rx_active) begin
                        st <= ST_CHK;
                    end
                end
                ST_RD_FLAGS: if (mem_ack) begin
                    hdr_status <= mem_rdata[31:16];
                    st <= mem_rdata[16 + FLG_EMPTY] ? ST_RD_PTR : ST_DROP;
                end
                ST_RD_PTR: if (mem_ack) begin
                    wr_ptr  <= mem_rdata[AW-1:0] & ~AW'(WORD_BYTES - 1);
                    buf_cnt <= '0;
                    st      <= ST_FILL;
                end
                ST_FILL: if (byte_ok) begin
                    if (!crc_phase && s_tlast) begin
                        crc_phase <= 1'b1;
                        crc_idx   <= '0;
                    end
                    if (skip) trunc <= 1'b1;
                    if (store) begin
                        buf_cnt   <= buf_cnt + CNT_W'(1);
                        frame_cnt <= frame_cnt + CNT_W'(1);
                        if (!crc_phase) pay_cnt <= pay_cnt + CNT_W'(1);
                        else            crc_idx <= crc_idx + 2'd1;
                        if (flush) begin
                            st         <= ST_WR_DATA;
                            frame_done <= last_byte;
                        end
                    end
                end
                ST_WR_DATA: if (mem_ack) begin
                    wr_ptr <= wr_ptr + AW'(WORD_BYTES);
                    st <= (frame_done || buf_cnt == buf_cap) ? ST_WR_DESC : ST_FILL;
                end
                ST_WR_DESC: if (mem_ack) begin
                    evt_rxf  <= frame_done;
                    evt_rxb  <= !frame_done;
                    cur_desc <= hdr_status[FLG_WRAP] ? ring_base : cur_desc + AW'(DESC_BYTES);
                    buf_cnt  <= '0;
                    st       <= frame_done ? ST_CHK : ST_RD_FLAGS;
                end
                ST_DROP: if (crc_phase || (s_tvalid && s_tlast)) begin
                    st <= ST_CHK;
                end
                ST_CHK: if (mem_ack) begin
                    if (ctl_enable) rx_active <= mem_rdata[16 + FLG_EMPTY];
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_BUF_CAP: assert property (@(posedge clk) disable iff (rst)
        buf_cnt <= buf_cap); // R4
    AST_FRAME_CAP: assert property (@(posedge clk) disable iff (rst)
        frame_cnt <= CNT_W'(FRAME_LIMIT)); // R2
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(evt_rxb && evt_rxf)); // R6
    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        !ctl_enable |=> !rx_active); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !s_tready); // R9
    AST_WRAP_RETURN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WR_DESC && mem_ack && hdr_status[FLG_WRAP]) |=> (cur_desc == $past(ring_base))); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata))); // R10
endmodule

// File: tb/rxq_ring_engine_bench.sv
module rxq_ring_engine_bench;
    localparam int AW    = 32;
    localparam int LIMIT = 2032;
    localparam int NDESC = 6;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [31:0] BUFS = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_enable = 1'b0, rx_activate = 1'b0;
    logic [AW-1:0] ring_base = BASE;
    logic [6:0] buf_units = 7'd1;
    logic [15:0] max_frame_len = 16'd1518;
    logic [7:0] s_tdata = '0;
    logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic rx_active, evt_rxb, evt_rxf;

    always #4 clk = ~clk;

    rxq_ring_engine #(.AW(AW), .FRAME_LIMIT(LIMIT)) u_rxq_ring_engine (
        .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .rx_activate(rx_activate),
        .ring_base(ring_base), .buf_units(buf_units), .max_frame_len(max_frame_len),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_active(rx_active), .evt_rxb(evt_rxb), .evt_rxf(evt_rxf));

    int checks = 0, failures = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [int];
    typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] be; } wr_t;
    wr_t expq[$];
    bit  evq[$];
    int  cyc = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        int k = int'(a >> 2);
        return mem.exists(k) ? mem[k] : 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            if (mem_we) begin
                logic [31:0] m, old;
                m = {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};
                if (expq.size() == 0) begin
                    check(1'b0, "R5 unexpected write", longint'(mem_addr), 0);
                end else begin
                    wr_t e;
                    e = expq.pop_front();
                    check(mem_addr == e.a, "R10 write address", longint'(mem_addr), longint'(e.a));
                    check(mem_be == e.be, "R11 byte enables", longint'(mem_be), longint'(e.be));
                    check((mem_wdata & m) == (e.d & m), "R1 R6 write data",
                          longint'(mem_wdata & m), longint'(e.d & m));
                end
                old = rd(mem_addr);
                mem[int'(mem_addr >> 2)] = (old & ~m) | (mem_wdata & m);
            end
        end else if (mem_req && (cyc % 3) != 1) begin
            mem_ack   <= 1'b1;
            mem_rdata <= rd(mem_addr);
        end
    end

    always @(posedge clk) begin
        if (!rst && (evt_rxb || evt_rxf)) begin
            if (evq.size() == 0) begin
                check(1'b0, "R6 unexpected event", {evt_rxf, evt_rxb}, 0);
            end else begin
                bit e;
                e = evq.pop_front();
                check(evt_rxf == e && evt_rxb == !e, "R6 event kind",
                      {evt_rxf, evt_rxb}, {e, !e});
            end
        end
    end

    // ---------------- reference model ----------------
    logic [31:0] m_cur;

    function automatic logic [31:0] ref_crc(input byte unsigned p[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (p[i]) begin
            c = c ^ {24'd0, p[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic bit model_frame(input byte unsigned p[$]);
        byte unsigned sq[$];
        logic [31:0] fc;
        int kept, total, cap, pos;
        bit tr, lg;
        fc   = ref_crc(p);
        kept = (p.size() > LIMIT - 4) ? LIMIT - 4 : p.size();
        for (int i = 0; i < kept; i++) sq.push_back(p[i]);
        for (int i = 0; i < 4; i++) sq.push_back(fc[8*i +: 8]);
        tr    = p.size() > kept;
        total = sq.size();
        lg    = tr || (total > int'(max_frame_len));
        cap   = (buf_units == 0) ? 16 : int'(buf_units) * 16;
        pos   = 0;
        while (pos < total) begin
            logic [15:0] fl, fo;
            logic [31:0] bp;
            int chunk;
            fl = rd(m_cur)[31:16];
            if (!fl[15]) break;
            bp = rd(m_cur + 4) & ~32'd3;
            chunk = (total - pos < cap) ? total - pos : cap;
            for (int o = 0; o < chunk; o += 4) begin
                wr_t w;
                w.a = bp + o; w.d = '0; w.be = '0;
                for (int l = 0; l < 4; l++) if (o + l < chunk) begin
                    w.d[8*l +: 8] = sq[pos + o + l];
                    w.be[l] = 1'b1;
                end
                expq.push_back(w);
            end
            pos += chunk;
            fo = fl & ~16'h8000;
            if (pos == total) fo = fo | 16'h0800 | (tr ? 16'h0001 : 16'h0) | (lg ? 16'h0020 : 16'h0);
            begin
                wr_t w;
                w.a = m_cur; w.d = {fo, 16'(chunk)}; w.be = 4'hF;
                expq.push_back(w);
            end
            evq.push_back(pos == total);
            m_cur = fl[13] ? BASE : m_cur + 8;
        end
        return rd(m_cur)[31];
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic rearm(input int hole);
        for (int i = 0; i < NDESC; i++) begin
            logic [15:0] f;
            f = ((i == hole) ? 16'h0 : 16'h8000) | ((i == NDESC - 1) ? 16'h2000 : 16'h0)
              | ((i % 2) ? 16'h0100 : 16'h0);
            mem[int'((BASE + 8*i) >> 2)] = {f, 16'h0};
            mem[int'((BASE + 8*i + 4) >> 2)] = BUFS + 32'h800 * i;
        end
    endtask

    task automatic activate();
        @(negedge clk) rx_activate = 1'b1;
        @(negedge clk) rx_activate = 1'b0;
        for (int i = 0; i < 40 && !rx_active; i++) @(negedge clk);
    endtask

    task automatic drive(input byte unsigned p[$], input int gap);
        foreach (p[i]) begin
            bit hs;
            if (gap > 0 && (i % gap) == gap - 1) begin
                s_tvalid = 1'b0;
                @(negedge clk);
            end
            s_tvalid = 1'b1; s_tdata = p[i]; s_tlast = (i == p.size() - 1);
            hs = 1'b0;
            while (!hs) begin
                #3 hs = s_tready;
                @(negedge clk);
            end
        end
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic run_frame(input int n, input int gap, input int seed, input int hole, input string req);
        byte unsigned p[$];
        bit exp_act;
        for (int i = 0; i < n; i++) p.push_back(byte'((seed * 7 + i * 13 + (i >> 3)) & 8'hFF));
        rearm(hole);
        if (!rx_active) activate();
        check(rx_active == 1'b1, {req, " R8 active before frame"}, rx_active, 1);
        exp_act = model_frame(p);
        drive(p, gap);
        for (int i = 0; i < 6000 && evq.size() != 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(evq.size() == 0, {req, " R6 events delivered"}, evq.size(), 0);
        check(expq.size() == 0, {req, " R6 writes delivered"}, expq.size(), 0);
        check(rx_active == exp_act, {req, " R8 active after frame"}, rx_active, exp_act);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        m_cur = BASE;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rx_active == 1'b0, "R9 reset rx_active", rx_active, 0);
        check(s_tready == 1'b0, "R9 reset s_tready", s_tready, 0);
        check(mem_req == 1'b0, "R10 reset mem_req", mem_req, 0);
        ctl_enable = 1'b1;
        repeat (3) @(negedge clk);
        check(rx_active == 1'b0, "R8 inactive before activate", rx_active, 0);

        buf_units = 7'd1;
        run_frame(10, 0, 1, -1, "R1 short frame");
        run_frame(40, 3, 2, -1, "R4 three buffers");
        run_frame(14, 0, 3, -1, "R1 check bytes spill");
        buf_units = 7'd3;
        run_frame(45, 2, 4, -1, "R4 one byte spill");
        buf_units = 7'd4; max_frame_len = 16'd64;
        run_frame(70, 0, 5, -1, "R3 over limit");
        run_frame(60, 0, 6, -1, "R3 equal to limit");
        buf_units = 7'd127; max_frame_len = 16'd1518;
        run_frame(2100, 0, 7, -1, "R2 truncated");
        run_frame(2028, 0, 8, -1, "R2 exactly at ceiling");
        check(m_cur != BASE + 8 * 2, "R7 ring wrapped", m_cur, 0);

        // R5: hole right after the current descriptor
        buf_units = 7'd1;
        begin
            int nxt = (int'((m_cur - BASE) / 8) + 1) % NDESC;
            int hole_idx = nxt;
            logic [31:0] hole_addr = BASE + 8 * hole_idx;
            run_frame(40, 0, 9, hole_idx, "R5 ring hole");
            check(rx_active == 1'b0, "R5 R8 stalled on hole", rx_active, 0);
            mem[int'(hole_addr >> 2)] = mem[int'(hole_addr >> 2)] | 32'h8000_0000;
            activate();
            check(rx_active == 1'b1, "R8 activate re-check", rx_active, 1);
        end

        // R9: disable, stream held valid, nothing accepted
        @(negedge clk) ctl_enable = 1'b0;
        @(negedge clk);
        check(rx_active == 1'b0, "R9 disable drops active", rx_active, 0);
        s_tvalid = 1'b1; s_tdata = 8'h5A;
        begin
            bit seen = 1'b0;
            repeat (20) begin #3 if (s_tready) seen = 1'b1; @(negedge clk); end
            check(seen == 1'b0, "R9 no ready while inactive", seen, 0);
        end
        s_tvalid = 1'b0;
        check(expq.size() == 0 && evq.size() == 0, "R9 no memory traffic", expq.size(), 0);
        m_cur = BASE;
        ctl_enable = 1'b1;
        buf_units = 7'd2;
        run_frame(20, 1, 10, -1, "R7 reload from ring start");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule